// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block carries out maintenance commands on the tag/state array of a set-associative cache. It takes one command at a time, together with a 32-bit operand. It walks the affected lines through an external tag array port. When a line holds modified data, it hands that line to an external write-back engine and waits for the engine to acknowledge before it updates the tag. The data array and the refill path are not part of this block.

Seven operations are supported:
- Clean a line found by address.
- Invalidate a line found by address.
- Clean a line chosen by an explicit set/way operand.
- Invalidate a line chosen by an explicit set/way operand.
- Invalidate the whole cache.
- Flush a line chosen by a physical line number.
- Search for the first modified line.

Each command raises `busy_o` from acceptance until a one-cycle `done_o`. The dirty-line search leaves its result on a found flag and on set and way index outputs.

Each tag word has the following layout:
- Bit 0 is valid.
- Bit 1 marks the lower half of the line dirty.
- Bit 2 marks the upper half of the line dirty.
- Bits 3 and up hold the address tag, which is `addr[31:OFF_W+SET_W]`.

The set index is `addr[OFF_W+SET_W-1:OFF_W]`, where `OFF_W = log2(LINE_BYTES)`. The 3-bit opcodes are:
- 0: clean by address
- 1: invalidate by address
- 2: clean by set/way
- 3: invalidate by set/way
- 4: invalidate all
- 5: flush by line number
- 6: find dirty
- 7: reserved

Top module: `cmo_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `tag_wr_en_o` and `wb_req_o` are low.
- R2: A command is accepted only when `busy_o` is low. `busy_o` then stays high up to and including the single cycle in which `done_o` is high, and it is low in the following cycle. Commands presented while busy are ignored.
- R3: Clean by address (op 0) compares the tag of every way of the addressed set. A valid matching line gets a write-back of its dirty halves (`wb_half_o` bit 0 for the lower half, bit 1 for the upper half), and its dirty bits are cleared while valid and tag are kept. A miss, including a matching tag on an invalid line, causes no write-back and no tag change.
- R4: Invalidate by address (op 1) writes back a valid hit's dirty halves first and then writes the whole tag word to zero.
- R5: In a set/way operand, the way is `arg[31 -: WAY_W]` and the set is `arg[OFF_W +: SET_W]`. All other bits are ignored and no tag compare is made. Op 2 cleans that line and op 3 invalidates it, by the rules of R3 and R4.
- R6: Invalidate all (op 4) visits every line, ascending by set and within a set ascending by way. It writes back every valid dirty line in that order and leaves every tag word zero.
- R7: Flush by line number (op 5) takes `line = arg >> OFF_W`. The way is `line[WAY_W-1:0]` and the set is `line[WAY_W +: SET_W]`. That line is written back if it is valid and dirty, and then its tag word is zeroed.
- R8: Find dirty (op 6) scans sets in ascending order, and ways in ascending order within each set. It stops at the first line with either dirty bit set and reports `found_o`=1 with that line's set and way. If no line is dirty it reports `found_o`=0. It writes back nothing and changes no tag. The result holds until the next command.
- R9: `wb_req_o` stays high, with stable set, way and half, until `wb_ack_i`. Only a valid line with a nonzero dirty field is requested. Invalid or clean lines get no request.
- R10: Opcode 7 completes with `done_o` and has no effect on tags or write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation code |
| cmd_arg_i | input | 32 | Address, set/way or line-number operand |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command completed (one cycle) |
| found_o | output | 1 | Dirty search found a line |
| found_set_o | output | SET_W | Set of found line |
| found_way_o | output | WAY_W | Way of found line |
| tag_rd_set_o | output | SET_W | Tag read set |
| tag_rd_way_o | output | WAY_W | Tag read way |
| tag_rd_data_i | input | TW | Tag word read (same cycle) |
| tag_wr_en_o | output | 1 | Tag write enable |
| tag_wr_set_o | output | SET_W | Tag write set |
| tag_wr_way_o | output | WAY_W | Tag write way |
| tag_wr_data_o | output | TW | Tag write word |
| wb_req_o | output | 1 | Write-back request |
| wb_set_o | output | SET_W | Write-back set |
| wb_way_o | output | WAY_W | Write-back way |
| wb_half_o | output | 2 | Halves to write back |
| wb_ack_i | input | 1 | Write-back engine acknowledge |

## Verification
The hardest situation to reach is a command arriving while a long write-back is outstanding. The bench's write-back engine model holds off its acknowledge for several cycles. During that window it presents a second command aimed at a different valid line, then checks that this line is untouched and that only one write-back took place. Ordering is the other subtle point. Invalidate-all and find-dirty are each given several dirty lines spread over sets and ways, so that a wrong loop order shows up in the logged write-back sequence or in the reported indices.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [2:0] {
    OP_CLEAN_VA   = 3'd0,
    OP_INVAL_VA   = 3'd1,
    OP_CLEAN_SW   = 3'd2,
    OP_INVAL_SW   = 3'd3,
    OP_INVAL_ALL  = 3'd4,
    OP_FLUSH_LN   = 3'd5,
    OP_FIND_DIRTY = 3'd6,
    OP_RSVD       = 3'd7
  } cmo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LINE, ST_WB, ST_UPD, ST_DONE
  } cmo_state_e;

  localparam int VALID_BIT = 0;
  localparam int DLO_BIT   = 1;
  localparam int DHI_BIT   = 2;
  localparam int TAG_LSB   = 3;

  function automatic logic op_clears(cmo_op_e op);
    return op inside {OP_INVAL_VA, OP_INVAL_SW, OP_INVAL_ALL, OP_FLUSH_LN};
  endfunction
endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
  import cmo_pkg::*;
#(
  parameter int SET_W = 3,
  parameter int WAY_W = 2,
  parameter int OFF_W = 5,
  parameter int TAG_W = 24
) (
  input  cmo_op_e            op_i,
  input  logic [31:0]        arg_i,
  output logic [SET_W-1:0]   set_o,
  output logic [WAY_W-1:0]   way_o,
  output logic [TAG_W-1:0]   tag_o
);
  logic [31:0] line_num;

  assign line_num = arg_i >> OFF_W;
  assign tag_o    = arg_i[31 -: TAG_W];

  always_comb begin
    set_o = '0;
    way_o = '0;
    unique case (op_i)
      OP_CLEAN_VA, OP_INVAL_VA: begin
        set_o = arg_i[OFF_W +: SET_W];
      end
      OP_CLEAN_SW, OP_INVAL_SW: begin
        set_o = arg_i[OFF_W +: SET_W];
        way_o = arg_i[31 -: WAY_W];
      end
      OP_FLUSH_LN: begin
        way_o = line_num[WAY_W-1:0];
        set_o = line_num[WAY_W +: SET_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmo_cursor.sv
module cmo_cursor #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic             step_i,
  output logic [SET_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o,
  output logic             last_way_o,
  output logic             last_o
);
  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;

  assign last_way_o = (way_q == WAY_W'(WAYS - 1));
  assign last_o     = last_way_o && (set_q == SET_W'(SETS - 1));
  assign set_o      = set_q;
  assign way_o      = way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
      way_q <= '0;
    end else if (load_i) begin
      set_q <= set_i;
      way_q <= way_i;
    end else if (step_i) begin
      if (last_way_o) begin
        way_q <= '0;
        set_q <= set_q + 1'b1;
      end else begin
        way_q <= way_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmo_line_eval.sv
module cmo_line_eval
  import cmo_pkg::*;
#(
  parameter int TAG_W = 24,
  localparam int TW = TAG_W + TAG_LSB
) (
  input  logic [TW-1:0]    word_i,
  input  logic [TAG_W-1:0] cmp_tag_i,
  output logic             valid_o,
  output logic             hit_o,
  output logic [1:0]       dirty_o,
  output logic [TW-1:0]    clean_word_o
);
  assign valid_o = word_i[VALID_BIT];
  assign hit_o   = valid_o && (word_i[TAG_LSB +: TAG_W] == cmp_tag_i);
  assign dirty_o = {word_i[DHI_BIT], word_i[DLO_BIT]};

  always_comb begin
    clean_word_o          = word_i;
    clean_word_o[DLO_BIT] = 1'b0;
    clean_word_o[DHI_BIT] = 1'b0;
  end
endmodule

// File: rtl/cmo_seq.sv
module cmo_seq
  import cmo_pkg::*;
#(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  parameter int LINE_BYTES = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int TAG_W = 32 - OFF_W - SET_W,
  localparam int TW = TAG_W + TAG_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [31:0]      cmd_arg_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             found_o,
  output logic [SET_W-1:0] found_set_o,
  output logic [WAY_W-1:0] found_way_o,
  output logic [SET_W-1:0] tag_rd_set_o,
  output logic [WAY_W-1:0] tag_rd_way_o,
  input  logic [TW-1:0]    tag_rd_data_i,
  output logic             tag_wr_en_o,
  output logic [SET_W-1:0] tag_wr_set_o,
  output logic [WAY_W-1:0] tag_wr_way_o,
  output logic [TW-1:0]    tag_wr_data_o,
  output logic             wb_req_o,
  output logic [SET_W-1:0] wb_set_o,
  output logic [WAY_W-1:0] wb_way_o,
  output logic [1:0]       wb_half_o,
  input  logic             wb_ack_i
);
  cmo_state_e       state_q, state_d;
  cmo_op_e          op_q;
  logic [TAG_W-1:0] cmp_tag_q;
  logic [TW-1:0]    word_q;
  logic [1:0]       half_q;
  logic             found_q;
  logic [SET_W-1:0] fset_q;
  logic [WAY_W-1:0] fway_q;

  logic             accept, step, act, fnd;
  logic [SET_W-1:0] dec_set, cur_set;
  logic [WAY_W-1:0] dec_way, cur_way;
  logic [TAG_W-1:0] dec_tag;
  logic             last_way, last;
  logic             ln_valid, ln_hit;
  logic [1:0]       ln_dirty;
  logic [TW-1:0]    ln_clean;

  assign accept = (state_q == ST_IDLE) && cmd_valid_i;

  cmo_decode #(
    .SET_W(SET_W), .WAY_W(WAY_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
  ) u_dec (
    .op_i  (cmo_op_e'(cmd_op_i)),
    .arg_i (cmd_arg_i),
    .set_o (dec_set),
    .way_o (dec_way),
    .tag_o (dec_tag)
  );

  cmo_cursor #(.SETS(SETS), .WAYS(WAYS)) u_cur (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .set_i      (dec_set),
    .way_i      (dec_way),
    .step_i     (step),
    .set_o      (cur_set),
    .way_o      (cur_way),
    .last_way_o (last_way),
    .last_o     (last)
  );

  cmo_line_eval #(.TAG_W(TAG_W)) u_eval (
    .word_i       (tag_rd_data_i),
    .cmp_tag_i    (cmp_tag_q),
    .valid_o      (ln_valid),
    .hit_o        (ln_hit),
    .dirty_o      (ln_dirty),
    .clean_word_o (ln_clean)
  );

  always_comb begin
    state_d = state_q;
    step    = 1'b0;
    act     = 1'b0;
    fnd     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LINE;
      ST_LINE: begin
        unique case (op_q)
          OP_CLEAN_VA, OP_INVAL_VA: begin
            if (ln_hit)        act = 1'b1;
            else if (last_way) state_d = ST_DONE;
            else               step = 1'b1;
          end
          OP_CLEAN_SW, OP_INVAL_SW, OP_FLUSH_LN, OP_INVAL_ALL: act = 1'b1;
          OP_FIND_DIRTY: begin
            if (|ln_dirty) begin
              fnd     = 1'b1;
              state_d = ST_DONE;
            end else if (last) begin
              state_d = ST_DONE;
            end else begin
              step = 1'b1;
            end
          end
          default: state_d = ST_DONE;
        endcase
        if (act) state_d = (ln_valid && |ln_dirty) ? ST_WB : ST_UPD;
      end
      ST_WB: if (wb_ack_i) state_d = ST_UPD;
      ST_UPD: begin
        if (op_q == OP_INVAL_ALL && !last) begin
          step    = 1'b1;
          state_d = ST_LINE;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_RSVD;
      cmp_tag_q <= '0;
      word_q    <= '0;
      half_q    <= '0;
      found_q   <= 1'b0;
      fset_q    <= '0;
      fway_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q      <= cmo_op_e'(cmd_op_i);
        cmp_tag_q <= dec_tag;
        found_q   <= 1'b0;
      end
      if (act) begin
        word_q <= ln_clean;
        half_q <= ln_valid ? ln_dirty : 2'b00;
      end
      if (fnd) begin
        found_q <= 1'b1;
        fset_q  <= cur_set;
        fway_q  <= cur_way;
      end
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign found_o       = found_q;
  assign found_set_o   = fset_q;
  assign found_way_o   = fway_q;
  assign tag_rd_set_o  = cur_set;
  assign tag_rd_way_o  = cur_way;
  assign tag_wr_en_o   = (state_q == ST_UPD);
  assign tag_wr_set_o  = cur_set;
  assign tag_wr_way_o  = cur_way;
  assign tag_wr_data_o = op_clears(op_q) ? '0 : word_q;
  assign wb_req_o      = (state_q == ST_WB);
  assign wb_set_o      = cur_set;
  assign wb_way_o      = cur_way;
  assign wb_half_o     = half_q;
endmodule

// File: rtl/cmo_seq_chk.sv
module cmo_seq_chk #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             found_o,
  input logic             tag_wr_en_o,
  input logic             wb_req_o,
  input logic             wb_ack_i,
  input logic [SET_W-1:0] wb_set_o,
  input logic [WAY_W-1:0] wb_way_o,
  input logic [1:0]       wb_half_o
);
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_valid_i |=> busy_o);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R2
  act_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_wr_en_o || wb_req_o || done_o) |-> busy_o);

  // R9
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_set_o) && $stable(wb_way_o)
      && $stable(wb_half_o));

  // R9
  wb_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> wb_half_o != 2'b00);

  // R8
  found_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !cmd_valid_i |=> $stable(found_o));
endmodule

bind cmo_seq cmo_seq_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (.*);

// File: tb/sim_cmo_seq.sv
module sim_cmo_seq;
  localparam int SETS = 8;
  localparam int WAYS = 4;
  localparam int SET_W = 3;
  localparam int WAY_W = 2;
  localparam int TW = 27;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic [2:0]       cmd_op_i = '0;
  logic [31:0]      cmd_arg_i = '0;
  logic             busy_o, done_o, found_o;
  logic [SET_W-1:0] found_set_o, tag_rd_set_o, tag_wr_set_o, wb_set_o;
  logic [WAY_W-1:0] found_way_o, tag_rd_way_o, tag_wr_way_o, wb_way_o;
  logic [TW-1:0]    tag_rd_data_i, tag_wr_data_o;
  logic             tag_wr_en_o, wb_req_o;
  logic [1:0]       wb_half_o;
  logic             wb_ack = 1'b0;

  logic [TW-1:0]    mem  [SETS*WAYS];
  logic [TW-1:0]    snap [SETS*WAYS];
  logic [SET_W-1:0] lg_set [64];
  logic [WAY_W-1:0] lg_way [64];
  logic [1:0]       lg_half [64];
  int               wb_n = 0;
  int               dly = 0;
  int               checks = 0;
  int               failures = 0;
  bit               ended = 1'b0;

  always #5 clk = ~clk;

  cmo_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_arg_i(cmd_arg_i), .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
    .found_set_o(found_set_o), .found_way_o(found_way_o),
    .tag_rd_set_o(tag_rd_set_o), .tag_rd_way_o(tag_rd_way_o),
    .tag_rd_data_i(tag_rd_data_i), .tag_wr_en_o(tag_wr_en_o),
    .tag_wr_set_o(tag_wr_set_o), .tag_wr_way_o(tag_wr_way_o),
    .tag_wr_data_o(tag_wr_data_o), .wb_req_o(wb_req_o), .wb_set_o(wb_set_o),
    .wb_way_o(wb_way_o), .wb_half_o(wb_half_o), .wb_ack_i(wb_ack)
  );

  assign tag_rd_data_i = mem[int'(tag_rd_set_o) * WAYS + int'(tag_rd_way_o)];

  always @(posedge clk) begin
    if (tag_wr_en_o) mem[int'(tag_wr_set_o) * WAYS + int'(tag_wr_way_o)] = tag_wr_data_o;
  end

  always @(posedge clk) begin
    if (wb_ack) begin
      wb_ack <= 1'b0;
    end else if (wb_req_o) begin
      if (dly == 2) begin
        wb_ack <= 1'b1;
        dly = 0;
        if (wb_n < 64) begin
          lg_set[wb_n]  = wb_set_o;
          lg_way[wb_n]  = wb_way_o;
          lg_half[wb_n] = wb_half_o;
        end
        wb_n = wb_n + 1;
      end else begin
        dly = dly + 1;
      end
    end
  end

  function automatic logic [TW-1:0] mk(logic [23:0] t, bit dhi, bit dlo, bit v);
    return {t, dhi, dlo, v};
  endfunction

  function automatic logic [31:0] va(logic [23:0] t, logic [2:0] s, logic [4:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < SETS*WAYS; i++) mem[i] = '0;
  endtask

  task automatic put(input int s, input int w, input logic [TW-1:0] d);
    mem[s*WAYS + w] = d;
  endtask

  function automatic logic [TW-1:0] get(input int s, input int w);
    return mem[s*WAYS + w];
  endfunction

  task automatic take_snap();
    for (int i = 0; i < SETS*WAYS; i++) snap[i] = mem[i];
  endtask

  function automatic int diffs();
    int n = 0;
    for (int i = 0; i < SETS*WAYS; i++) if (mem[i] !== snap[i]) n++;
    return n;
  endfunction

  task automatic run_cmd(input logic [2:0] op, input logic [31:0] arg);
    wb_n = 0;
    @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_arg_i   = arg;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    while (!done_o) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "wb_req", wb_req_o, 0);
    chk("R1", "tag_wr", tag_wr_en_o, 0);
  endtask

  task automatic t_clean_va();
    clear_mem();
    put(2, 0, mk(24'h000011, 0, 0, 1));
    put(2, 3, mk(24'h000ABC, 1, 1, 1));
    put(4, 1, mk(24'h000055, 1, 0, 0));
    run_cmd(3'd0, va(24'h000ABC, 3'd2, 5'd7));
    chk("R3", "hit wb count", wb_n, 1);
    chk("R3", "hit wb set/way/half", {lg_set[0], lg_way[0], lg_half[0]}, {3'd2, 2'd3, 2'd3});
    chk("R3", "hit tag kept valid", get(2, 3), mk(24'h000ABC, 0, 0, 1));
    chk("R3", "other way", get(2, 0), mk(24'h000011, 0, 0, 1));
    put(2, 3, mk(24'h000ABC, 1, 1, 1));
    take_snap();
    run_cmd(3'd0, va(24'h000DEF, 3'd2, 5'd0));
    chk("R3", "miss wb count", wb_n, 0);
    chk("R3", "miss tags", diffs(), 0);
    run_cmd(3'd0, va(24'h000055, 3'd4, 5'd0));
    chk("R3", "invalid match wb count", wb_n, 0);
    chk("R3", "invalid match tags", diffs(), 0);
  endtask

  task automatic t_inval_va();
    clear_mem();
    put(5, 2, mk(24'h000077, 0, 1, 1));
    put(5, 1, mk(24'h000078, 0, 0, 1));
    run_cmd(3'd1, va(24'h000077, 3'd5, 5'd4));
    chk("R4", "wb count", wb_n, 1);
    chk("R4", "wb set/way/half", {lg_set[0], lg_way[0], lg_half[0]}, {3'd5, 2'd2, 2'd1});
    chk("R4", "tag zero", get(5, 2), 0);
    run_cmd(3'd1, va(24'h000078, 3'd5, 5'd0));
    chk("R9", "clean hit no wb", wb_n, 0);
    chk("R4", "clean hit tag zero", get(5, 1), 0);
  endtask

  task automatic t_set_way();
    clear_mem();
    put(6, 1, mk(24'h000099, 1, 0, 1));
    put(3, 3, mk(24'h000001, 1, 1, 0));
    run_cmd(3'd2, (32'd1 << 30) | 32'h0012_3400 | (32'd6 << 5) | 32'd9);
    chk("R5", "clean wb count", wb_n, 1);
    chk("R5", "clean wb set/way/half", {lg_set[0], lg_way[0], lg_half[0]}, {3'd6, 2'd1, 2'd2});
    chk("R5", "clean tag", get(6, 1), mk(24'h000099, 0, 0, 1));
    run_cmd(3'd3, (32'd3 << 30) | (32'd3 << 5));
    chk("R9", "invalid dirty no wb", wb_n, 0);
    chk("R5", "inval tag zero", get(3, 3), 0);
  endtask

  task automatic t_flush();
    clear_mem();
    put(7, 2, mk(24'h000044, 1, 1, 1));
    put(7, 1, mk(24'h000045, 1, 1, 1));
    run_cmd(3'd5, ((32'd7 << 2) | 32'd2) << 5 | 32'd3);
    chk("R7", "wb count", wb_n, 1);
    chk("R7", "wb set/way/half", {lg_set[0], lg_way[0], lg_half[0]}, {3'd7, 2'd2, 2'd3});
    chk("R7", "tag zero", get(7, 2), 0);
    chk("R7", "neighbour", get(7, 1), mk(24'h000045, 1, 1, 1));
  endtask

  task automatic t_inval_all();
    clear_mem();
    put(6, 2, mk(24'h000003, 1, 0, 1));
    put(1, 0, mk(24'h000002, 1, 1, 1));
    put(0, 3, mk(24'h000001, 0, 1, 1));
    put(2, 2, mk(24'h000004, 0, 0, 1));
    put(4, 0, mk(24'h000005, 1, 1, 0));
    run_cmd(3'd4, 32'hFFFF_FFFF);
    chk("R6", "wb count", wb_n, 3);
    chk("R6", "wb #0", {lg_set[0], lg_way[0], lg_half[0]}, {3'd0, 2'd3, 2'd1});
    chk("R6", "wb #1", {lg_set[1], lg_way[1], lg_half[1]}, {3'd1, 2'd0, 2'd3});
    chk("R6", "wb #2", {lg_set[2], lg_way[2], lg_half[2]}, {3'd6, 2'd2, 2'd2});
    for (int i = 0; i < SETS*WAYS; i++) snap[i] = '0;
    chk("R6", "nonzero tags", diffs(), 0);
  endtask

  task automatic t_find();
    clear_mem();
    put(5, 0, mk(24'h000010, 1, 0, 1));
    put(3, 3, mk(24'h000011, 0, 1, 1));
    put(3, 2, mk(24'h000012, 0, 1, 1));
    put(1, 1, mk(24'h000013, 0, 0, 1));
    take_snap();
    run_cmd(3'd6, 32'd0);
    chk("R8", "found", found_o, 1);
    chk("R8", "set/way", {found_set_o, found_way_o}, {3'd3, 2'd2});
    chk("R8", "no wb", wb_n, 0);
    chk("R8", "tags untouched", diffs(), 0);
    repeat (3) @(negedge clk);
    chk("R8", "result held", {found_o, found_set_o, found_way_o}, {1'b1, 3'd3, 2'd2});
    clear_mem();
    put(1, 1, mk(24'h000013, 0, 0, 1));
    put(7, 3, mk(24'h000014, 0, 0, 1));
    run_cmd(3'd6, 32'd0);
    chk("R8", "not found", found_o, 0);
  endtask

  task automatic t_busy();
    clear_mem();
    put(0, 0, mk(24'h000021, 1, 1, 1));
    put(4, 2, mk(24'h000022, 1, 1, 1));
    wb_n = 0;
    @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_op_i    = 3'd2;
    cmd_arg_i   = 32'd0;
    @(negedge clk);
    cmd_op_i    = 3'd3;
    cmd_arg_i   = (32'd2 << 30) | (32'd4 << 5);
    @(negedge clk);
    chk("R2", "busy during cmd", busy_o, 1);
    @(negedge clk);
    cmd_valid_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R2", "busy at done", busy_o, 1);
    @(negedge clk);
    chk("R2", "idle after done", busy_o, 0);
    chk("R2", "one wb", wb_n, 1);
    chk("R2", "ignored line intact", get(4, 2), mk(24'h000022, 1, 1, 1));
    chk("R2", "first cmd done", get(0, 0), mk(24'h000021, 0, 0, 1));
  endtask

  task automatic t_rsvd();
    clear_mem();
    put(0, 0, mk(24'h000031, 1, 1, 1));
    take_snap();
    run_cmd(3'd7, 32'd0);
    chk("R10", "done seen", done_o, 1);
    chk("R10", "no wb", wb_n, 0);
    chk("R10", "tags", diffs(), 0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_va();
    t_inval_va();
    t_set_way();
    t_flush();
    t_inval_all();
    t_find();
    t_busy();
    t_rsvd();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule